// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating converter. The integrator, the comparator and the reference source sit outside it. A start pulse begins a conversion. The block first holds the integrator on the unknown input for a fixed number of clock cycles, set by the result width. It then clears its cycle counter and switches the integrator to the reference. It counts again until the comparator reports that the integrator has crossed its threshold.

The count reached at the crossing becomes the conversion result. A one-cycle done pulse marks the cycle in which it becomes valid. If the comparator never trips before the counter fills, the result saturates at full scale and an overrange flag is raised. Both phases are timed by the same clock, so the result is a ratio of cycle counts and does not depend on the clock period.

Top module: `dual_slope_seq`

## Requirements
- R1: While reset is held low at a rising edge, and afterwards until a start is accepted: ref_sel=0, done=0, result=0, overrange=0, cnt_clr=1.
- R2: A start sampled high in the idle state begins the integrate phase. ref_sel stays 0 (unknown input selected) and first reads 1 after the (2^N+1)-th rising edge, counting the edge that sampled start.
- R3: cnt_clr is 0 while the integrate phase counts. It is 1 in the final integrate cycle, when the counter is reset before the reference phase.
- R4: During the reference phase ref_sel=1 and the counter starts from 0 and advances once per clock. If cmp_trip is sampled high while the count is k, result becomes k and ref_sel stays high for exactly k+1 cycles.
- R5: If the count reaches 2^N-1 with cmp_trip low, result becomes all ones and overrange=1. A trip sampled at count 2^N-1 gives result all ones with overrange=0.
- R6: done is high for exactly one cycle, the cycle after the last reference cycle. In that cycle result and overrange already hold the new values and ref_sel is 0.
- R7: A start outside the idle state, including in the done cycle, is ignored. The running conversion keeps its timing and result, and no new conversion follows.
- R8: result and overrange keep their values until the next conversion completes, whatever start-free activity happens on cmp_trip.
- R9: For the same analog condition, the result does not depend on the clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Conversion clock timing both phases |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Conversion request, honoured only when idle |
| cmp_trip | input | 1 | Comparator output, high once the integrator crosses its threshold |
| ref_sel | output | 1 | Integrator input select: 0 unknown signal, 1 reference |
| cnt_clr | output | 1 | High while the cycle counter is being reset |
| result | output | RES_W | Captured conversion count |
| overrange | output | 1 | Set when the reference phase saturated without a trip |
| done | output | 1 | One-cycle pulse when a new result is valid |

## Verification
The assertions assume that cmp_trip matters only while the reference is selected. They also assume that start and cmp_trip change only between clock edges. The bench therefore gates its comparator model with ref_sel and drives every input on the falling edge. The comparator model trips once the number of elapsed reference cycles reaches the applied level. A sweep over every level from zero to beyond full scale covers the exact-full-scale trip and the saturation case. Stray start pulses are placed inside each non-idle state, and one run is repeated at a slower clock.

// File: rtl/dsadc_pkg.sv
// Package: shared state encoding for the dual-slope sequencer.
// Assumes: used by all modules of dual_slope_seq.
package dsadc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INTEG = 2'd1,
        ST_DEINT = 2'd2,
        ST_DONE  = 2'd3
    } dsadc_state_e;
endpackage

// File: rtl/dsadc_count.sv
// Module: cycle counter shared by both conversion phases.
// Assumes: clr has priority over inc; width is a parameter.
module dsadc_count #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         at_full
);
    // Count register: reset, clear or advance by one.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;
    end

    // Full-count flag used for terminal and saturation detection.
    always_comb at_full = (cnt == {W{1'b1}});
endmodule

// File: rtl/dsadc_ctrl.sv
// Module: phase sequencer (idle, integrate, de-integrate, done).
// Assumes: integrate terminal count equals the counter's full value;
// cmp_trip is only meaningful in the de-integrate state.
module dsadc_ctrl
    import dsadc_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         cmp_trip,
    input  logic         at_full,
    output dsadc_state_e state,
    output logic         clr,
    output logic         inc,
    output logic         load,
    output logic         ovr_set
);
    dsadc_state_e nxt;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state and per-cycle counter and capture controls.
    always_comb begin
        nxt     = state;
        clr     = 1'b0;
        inc     = 1'b0;
        load    = 1'b0;
        ovr_set = 1'b0;
        unique case (state)
            ST_IDLE: begin
                clr = 1'b1;
                if (start) nxt = ST_INTEG;
            end
            ST_INTEG: begin
                if (at_full) begin
                    clr = 1'b1;
                    nxt = ST_DEINT;
                end else begin
                    inc = 1'b1;
                end
            end
            ST_DEINT: begin
                if (cmp_trip) begin
                    load = 1'b1;
                    nxt  = ST_DONE;
                end else if (at_full) begin
                    load    = 1'b1;
                    ovr_set = 1'b1;
                    nxt     = ST_DONE;
                end else begin
                    inc = 1'b1;
                end
            end
            ST_DONE: begin
                clr = 1'b1;
                nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Integrate is only ever entered from idle on an accepted start.
    assert_start_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INTEG && $past(state) != ST_INTEG) |->
            ($past(state) == ST_IDLE && $past(start)));

    // The done state lasts a single cycle.
    assert_done_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_IDLE));
endmodule

// File: rtl/dsadc_result.sv
// Module: result and overrange capture register.
// Assumes: load is a single-cycle strobe from the sequencer.
module dsadc_result #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         ovr_set,
    input  logic [W-1:0] cnt,
    output logic [W-1:0] result,
    output logic         overrange
);
    // Capture on load; saturate to full scale on overrange.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result    <= '0;
            overrange <= 1'b0;
        end else if (load) begin
            result    <= ovr_set ? {W{1'b1}} : cnt;
            overrange <= ovr_set;
        end
    end

    // Without a load the captured values stay put.
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(result) && $stable(overrange)));

    // Overrange always comes with a full-scale result.
    assert_sat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        overrange |-> (result == {W{1'b1}}));
endmodule

// File: rtl/dual_slope_seq.sv
// Module: top of the dual-slope conversion sequencer.
// Assumes: external integrator/comparator; ref_sel=0 selects the unknown
// input, 1 the reference; integrate terminal count is 2^RES_W-1.
module dual_slope_seq
    import dsadc_pkg::*;
#(
    parameter int RES_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             cmp_trip,
    output logic             ref_sel,
    output logic             cnt_clr,
    output logic [RES_W-1:0] result,
    output logic             overrange,
    output logic             done
);
    localparam logic [RES_W-1:0] FULL = {RES_W{1'b1}};

    dsadc_state_e     state;
    logic             clr, inc, load, ovr_set, at_full;
    logic [RES_W-1:0] cnt;

    dsadc_count #(.W(RES_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc),
        .cnt(cnt), .at_full(at_full)
    );

    dsadc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_trip(cmp_trip),
        .at_full(at_full), .state(state), .clr(clr), .inc(inc),
        .load(load), .ovr_set(ovr_set)
    );

    dsadc_result #(.W(RES_W)) u_res (
        .clk(clk), .rst_n(rst_n), .load(load), .ovr_set(ovr_set),
        .cnt(cnt), .result(result), .overrange(overrange)
    );

    // Output decode from the sequencer state.
    always_comb begin
        ref_sel = (state == ST_DEINT);
        done    = (state == ST_DONE);
        cnt_clr = clr;
    end

    // Integrate phase continues until the counter is full.
    assert_int_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INTEG && cnt != FULL) |=> (state == ST_INTEG && cnt == $past(cnt) + 1'b1));

    // End of integrate: counter cleared and reference selected next cycle.
    assert_swap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_INTEG && cnt == FULL) |=> (ref_sel && cnt == '0));

    // Reference phase advances the count by one per clock until it stops.
    assert_deint_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_sel && !cmp_trip && cnt != FULL) |=> (ref_sel && cnt == $past(cnt) + 1'b1));
endmodule

// File: tb/sim_dual_slope_seq.sv
module sim_dual_slope_seq;
    localparam int N    = 4;
    localparam int FULL = (1 << N) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cmp_trip;
    logic ref_sel, cnt_clr, overrange, done;
    logic [N-1:0] result;

    int half = 4;
    int total = 0;
    int bad = 0;
    int vin = 0;
    int dk = 0;
    bit finished = 1'b0;

    always #(half) clk = ~clk;

    dual_slope_seq #(.RES_W(N)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_trip(cmp_trip),
        .ref_sel(ref_sel), .cnt_clr(cnt_clr), .result(result),
        .overrange(overrange), .done(done)
    );

    // Comparator model: trips once elapsed reference cycles reach the level.
    always @(posedge clk) dk <= ref_sel ? dk + 1 : 0;
    assign cmp_trip = ref_sel && (dk >= vin);

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One conversion at level v; stray pulses start in non-idle states.
    task automatic convert(input int v, input bit stray);
        int n = 1;
        int m = 0;
        int clr_early = 0;
        int clr_last = 0;
        int exp_r = (v > FULL) ? FULL : v;
        vin = v;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!ref_sel && n < 100) begin
            clr_last = cnt_clr;
            if (cnt_clr && n < FULL + 1) clr_early++;
            start = stray && (n == 3);
            @(negedge clk);
            start = 1'b0;
            n++;
        end
        chk("R2 integrate edges", n, FULL + 2);
        chk("R3 clear in last integrate cycle", clr_last, 1);
        chk("R3 no clear while counting", clr_early, 0);
        while (ref_sel && m < 100) begin
            start = stray && (m == 1);
            @(negedge clk);
            start = 1'b0;
            m++;
        end
        chk("R4 reference cycles", m, exp_r + 1);
        chk("R6 done high", done, 1);
        chk("R4 result", result, exp_r);
        chk("R5 overrange", overrange, (v > FULL) ? 1 : 0);
        start = stray;
        @(negedge clk);
        start = 1'b0;
        chk("R6 done single cycle", done, 0);
        chk("R8 result held", result, exp_r);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 ref_sel", ref_sel, 0);
        chk("R1 done", done, 0);
        chk("R1 result", result, 0);
        chk("R1 overrange", overrange, 0);
        chk("R1 cnt_clr", cnt_clr, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after release", ref_sel, 0);

        // R4, R5: sweep below, at and beyond full scale
        for (int v = 0; v <= FULL + 5; v++) convert(v, 1'b0);

        // R7: stray starts in integrate, reference and done states
        convert(6, 1'b1);
        begin
            int busy = 0;
            for (int i = 0; i < 20; i++) begin
                if (ref_sel || done || !cnt_clr) busy++;
                @(negedge clk);
            end
            chk("R7 no conversion after ignored start", busy, 0);
        end

        // R8: result holds through comparator activity without start
        convert(FULL + 3, 1'b0);
        vin = 0;
        repeat (30) @(negedge clk);
        chk("R8 result after idle", result, FULL);
        chk("R8 overrange after idle", overrange, 1);

        // R9: slower clock gives identical results
        half = 7;
        @(negedge clk);
        convert(9, 1'b0);
        convert(FULL, 1'b0);
        half = 4;
        @(negedge clk);
        convert(9, 1'b0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule